// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides, once per clock, whether the processor core must leave its normal flow to service an exception, or must come back from one. It watches seven exception request lines, a return strobe, the live status word, the address of the instruction the exception refers to, and the saved status word and link address of the current mode's bank. When it acts, it drives one-cycle write enables and data toward the status register, the per-mode saved status register, the per-mode link register and the program counter, along with the 5-bit code of the mode whose bank is addressed. The register file and the pipeline sit outside the block. A one-cycle flush pulse tells the pipeline to discard work that is in flight.

Requests that arrive together are reduced to one by a fixed priority. The IRQ and FIQ lines are gated by the interrupt-disable bits of the status word. On entry, the old status is preserved in the target mode's saved register, and a new status is formed: the target mode, the 32-bit instruction state and the proper disables. The link register receives a return address and the program counter jumps to a fixed vector. On return, status and program counter are reloaded from the current mode's banked copies. All outputs are registered, so each action appears one clock after the edge that sampled its inputs.

Top module: `trap_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, every write enable and flush are 0.
- R2: Of the requests present in a cycle only one is taken, in the order boot, data abort, FIQ, IRQ, fetch abort, undefined instruction, supervisor call (highest first). mode_sel names the bank: boot and supervisor call 5'h13, both aborts 5'h17, FIQ 5'h11, IRQ 5'h12, undefined 5'h1B.
- R3: An IRQ request is ignored while status bit 7 (IRQ disable) is 1, and an FIQ request is ignored while status bit 6 (FIQ disable) is 1. Lower-priority requests are then considered.
- R4: Every entry except boot writes the unmodified sampled status word into the saved status register (saved_we=1). Boot writes neither the saved status nor the link register.
- R5: On entry the new status equals the sampled status with bits [4:0] set to the target mode, bit 5 (instruction state) cleared, and bit 7 set. Bit 6 is set for boot and FIQ and is left unchanged otherwise. All other bits are unchanged.
- R6: On entry other than boot the link register receives pc_in+4, except for data abort, where it receives pc_in+8.
- R7: On entry the PC receives the vector base (0 by default) plus the offset 0x00 for boot, 0x04 for undefined, 0x08 for supervisor call, 0x0C for fetch abort, 0x10 for data abort, 0x18 for IRQ and 0x1C for FIQ.
- R8: A return writes bank_stat into the status register and bank_link into the PC, with mode_sel equal to the current mode field (status bits [4:0]). It writes neither the saved status nor the link register.
- R9: A return strobe is ignored while the current mode is User (5'h10) or System (5'h1F).
- R10: When an exception is taken in a cycle that also carries a return strobe, only the entry happens.
- R11: Outputs follow the sampling edge by one cycle. Flush is high for exactly that cycle, together with the status and PC write enables. In the cycle in which flush is high, all requests and the return strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_boot | input | 1 | Boot (reset) exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_svc | input | 1 | Supervisor call request |
| req_fetch_abt | input | 1 | Instruction fetch abort request |
| req_data_abt | input | 1 | Data access abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| ret_req | input | 1 | Return-from-exception strobe |
| stat_in | input | 32 | Current status word |
| pc_in | input | ADDR_W | Address of the affected instruction |
| bank_stat | input | 32 | Saved status of the current mode |
| bank_link | input | ADDR_W | Link address of the current mode |
| stat_we | output | 1 | Status register write enable |
| stat_wdata | output | 32 | Status register write data |
| saved_we | output | 1 | Saved status write enable (bank mode_sel) |
| saved_wdata | output | 32 | Saved status write data |
| link_we | output | 1 | Link register write enable (bank mode_sel) |
| link_wdata | output | ADDR_W | Link register write data |
| pc_we | output | 1 | Program counter write enable |
| pc_wdata | output | ADDR_W | Program counter write data |
| mode_sel | output | 5 | Bank addressed by this action |
| flush | output | 1 | One-cycle pipeline flush pulse |

## Verification
The bench sweeps all 128 combinations of request lines against all four settings of the two disable bits, with the return strobe asserted on half of them. A wrong priority chain would pick the wrong vector or bank. A mask applied to the wrong bit would let a disabled interrupt through or would starve a lower request. A misplaced link offset would show up on data abort alone. A boot entry that touched the saved or link bank would corrupt state that a handler relies on. A return sweep over every mode code shows whether User and System are correctly refused, and whether an exception in the same cycle pre-empts the return. The bench holds every stimulus across the flush cycle, so a missing lockout shows up as a second entry for a request that is still asserted.

// File: rtl/trap_pkg.sv
package trap_pkg;

   localparam int STAT_W = 32;
   localparam int SB_I   = 7;
   localparam int SB_F   = 6;
   localparam int SB_T   = 5;

   localparam logic [4:0] MD_USR = 5'h10;
   localparam logic [4:0] MD_FIQ = 5'h11;
   localparam logic [4:0] MD_IRQ = 5'h12;
   localparam logic [4:0] MD_SVC = 5'h13;
   localparam logic [4:0] MD_ABT = 5'h17;
   localparam logic [4:0] MD_UND = 5'h1B;
   localparam logic [4:0] MD_SYS = 5'h1F;

   // enumeration order is the priority order, highest first
   typedef enum logic [2:0] {
      TK_BOOT  = 3'd0,
      TK_DABT  = 3'd1,
      TK_FIQ   = 3'd2,
      TK_IRQ   = 3'd3,
      TK_PABT  = 3'd4,
      TK_UNDEF = 3'd5,
      TK_SVC   = 3'd6
   } trap_kind_e;

   localparam int NUM_KINDS = 7;
   localparam int KIND_W    = $clog2(NUM_KINDS);

   function automatic logic [4:0] kind_mode(input trap_kind_e k);
      case (k)
         TK_BOOT:  return MD_SVC;
         TK_DABT:  return MD_ABT;
         TK_FIQ:   return MD_FIQ;
         TK_IRQ:   return MD_IRQ;
         TK_PABT:  return MD_ABT;
         TK_UNDEF: return MD_UND;
         default:  return MD_SVC;
      endcase
   endfunction

   function automatic logic [4:0] kind_vec_off(input trap_kind_e k);
      case (k)
         TK_BOOT:  return 5'h00;
         TK_UNDEF: return 5'h04;
         TK_SVC:   return 5'h08;
         TK_PABT:  return 5'h0C;
         TK_DABT:  return 5'h10;
         TK_IRQ:   return 5'h18;
         default:  return 5'h1C;
      endcase
   endfunction

   function automatic logic kind_sets_f(input trap_kind_e k);
      return (k == TK_BOOT) || (k == TK_FIQ);
   endfunction

   function automatic logic kind_has_bank(input trap_kind_e k);
      return k != TK_BOOT;
   endfunction

endpackage

// File: rtl/trap_req_gate.sv
module trap_req_gate
   import trap_pkg::*;
(
   input  logic                 req_boot,
   input  logic                 req_undef,
   input  logic                 req_svc,
   input  logic                 req_fetch_abt,
   input  logic                 req_data_abt,
   input  logic                 req_irq,
   input  logic                 req_fiq,
   input  logic                 ret_req,
   input  logic                 irq_off,
   input  logic                 fiq_off,
   input  logic [4:0]           cur_mode,
   input  logic                 hold,
   output logic [NUM_KINDS-1:0] req_vec,
   output logic                 ret_go
);

   logic [NUM_KINDS-1:0] raw;
   logic                 has_bank;

   always_comb begin
      raw                 = '0;
      raw[int'(TK_BOOT)]  = req_boot;
      raw[int'(TK_DABT)]  = req_data_abt;
      raw[int'(TK_FIQ)]   = req_fiq & ~fiq_off;
      raw[int'(TK_IRQ)]   = req_irq & ~irq_off;
      raw[int'(TK_PABT)]  = req_fetch_abt;
      raw[int'(TK_UNDEF)] = req_undef;
      raw[int'(TK_SVC)]   = req_svc;
   end

   assign has_bank = (cur_mode != MD_USR) && (cur_mode != MD_SYS);
   assign req_vec  = hold ? '0 : raw;
   assign ret_go   = ~hold & ret_req & has_bank;

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter int N = NUM_KINDS,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] win_idx,
   output logic          any
);

   generate
      if (N < 2) begin : g_bad_n
         $error("trap_arbiter needs at least two request lines");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_pri
         if (gi == 0) begin : g_top
            assign grant[gi] = req[gi];
         end else begin : g_rest
            assign grant[gi] = req[gi] & ~|req[gi-1:0];
         end
      end
   endgenerate

   always_comb begin
      win_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) win_idx = win_idx | IW'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/trap_entry_calc.sv
module trap_entry_calc
   import trap_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int INST_BYTES = 4,
   parameter bit HIGH_VEC   = 1'b0
) (
   input  trap_kind_e         kind,
   input  logic [STAT_W-1:0]  cur_stat,
   input  logic [ADDR_W-1:0]  cur_pc,
   output logic [STAT_W-1:0]  new_stat,
   output logic [ADDR_W-1:0]  link_val,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic [4:0]         tgt_mode,
   output logic               bank_wr
);

   localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(INST_BYTES);
   localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2 * INST_BYTES);

   logic [ADDR_W-1:0] vec_base;

   generate
      if (HIGH_VEC) begin : g_vec_hi
         assign vec_base = {{(ADDR_W-16){1'b1}}, 16'h0000};
      end else begin : g_vec_lo
         assign vec_base = '0;
      end
   endgenerate

   always_comb begin
      tgt_mode         = kind_mode(kind);
      new_stat         = cur_stat;
      new_stat[SB_I]   = 1'b1;
      if (kind_sets_f(kind)) new_stat[SB_F] = 1'b1;
      new_stat[SB_T]   = 1'b0;
      new_stat[4:0]    = tgt_mode;
      bank_wr          = kind_has_bank(kind);
      link_val         = cur_pc + ((kind == TK_DABT) ? STEP_TWO : STEP_ONE);
      vec_addr         = vec_base | ADDR_W'(kind_vec_off(kind));
   end

endmodule

// File: rtl/trap_seq.sv
module trap_seq
   import trap_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int INST_BYTES = 4,
   parameter bit HIGH_VEC   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_boot,
   input  logic              req_undef,
   input  logic              req_svc,
   input  logic              req_fetch_abt,
   input  logic              req_data_abt,
   input  logic              req_irq,
   input  logic              req_fiq,
   input  logic              ret_req,
   input  logic [31:0]       stat_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [31:0]       bank_stat,
   input  logic [ADDR_W-1:0] bank_link,
   output logic              stat_we,
   output logic [31:0]       stat_wdata,
   output logic              saved_we,
   output logic [31:0]       saved_wdata,
   output logic              link_we,
   output logic [ADDR_W-1:0] link_wdata,
   output logic              pc_we,
   output logic [ADDR_W-1:0] pc_wdata,
   output logic [4:0]        mode_sel,
   output logic              flush
);

   generate
      if (ADDR_W < 20) begin : g_bad_addr
         $error("trap_seq: ADDR_W must be at least 20");
      end
      if (INST_BYTES != 2 && INST_BYTES != 4) begin : g_bad_inst
         $error("trap_seq: INST_BYTES must be 2 or 4");
      end
      if (STAT_W != 32) begin : g_bad_stat
         $error("trap_seq: status word must be 32 bits");
      end
   endgenerate

   logic [NUM_KINDS-1:0] req_vec;
   logic [NUM_KINDS-1:0] grant;
   logic [KIND_W-1:0]    win_idx;
   logic                 any_exc;
   logic                 ret_go;
   logic                 entry_q;
   logic                 ret_q;
   trap_kind_e           win_kind;
   logic [31:0]          ent_stat;
   logic [ADDR_W-1:0]    ent_link;
   logic [ADDR_W-1:0]    ent_vec;
   logic [4:0]           ent_mode;
   logic                 ent_bank;

   assign flush = entry_q | ret_q;

   trap_req_gate u_gate (
      .req_boot      (req_boot),
      .req_undef     (req_undef),
      .req_svc       (req_svc),
      .req_fetch_abt (req_fetch_abt),
      .req_data_abt  (req_data_abt),
      .req_irq       (req_irq),
      .req_fiq       (req_fiq),
      .ret_req       (ret_req),
      .irq_off       (stat_in[SB_I]),
      .fiq_off       (stat_in[SB_F]),
      .cur_mode      (stat_in[4:0]),
      .hold          (flush),
      .req_vec       (req_vec),
      .ret_go        (ret_go)
   );

   trap_arbiter #(.N(NUM_KINDS)) u_arb (
      .req     (req_vec),
      .grant   (grant),
      .win_idx (win_idx),
      .any     (any_exc)
   );

   assign win_kind = trap_kind_e'(win_idx);

   trap_entry_calc #(
      .ADDR_W     (ADDR_W),
      .INST_BYTES (INST_BYTES),
      .HIGH_VEC   (HIGH_VEC)
   ) u_entry (
      .kind     (win_kind),
      .cur_stat (stat_in),
      .cur_pc   (pc_in),
      .new_stat (ent_stat),
      .link_val (ent_link),
      .vec_addr (ent_vec),
      .tgt_mode (ent_mode),
      .bank_wr  (ent_bank)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_we     <= 1'b0;
         stat_wdata  <= '0;
         saved_we    <= 1'b0;
         saved_wdata <= '0;
         link_we     <= 1'b0;
         link_wdata  <= '0;
         pc_we       <= 1'b0;
         pc_wdata    <= '0;
         mode_sel    <= '0;
         entry_q     <= 1'b0;
         ret_q       <= 1'b0;
      end else begin
         stat_we  <= 1'b0;
         saved_we <= 1'b0;
         link_we  <= 1'b0;
         pc_we    <= 1'b0;
         entry_q  <= 1'b0;
         ret_q    <= 1'b0;
         if (any_exc) begin
            stat_we     <= 1'b1;
            stat_wdata  <= ent_stat;
            saved_we    <= ent_bank;
            saved_wdata <= stat_in;
            link_we     <= ent_bank;
            link_wdata  <= ent_link;
            pc_we       <= 1'b1;
            pc_wdata    <= ent_vec;
            mode_sel    <= ent_mode;
            entry_q     <= 1'b1;
         end else if (ret_go) begin
            stat_we    <= 1'b1;
            stat_wdata <= bank_stat;
            pc_we      <= 1'b1;
            pc_wdata   <= bank_link;
            mode_sel   <= stat_in[4:0];
            ret_q      <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk
   import trap_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       stat_in,
   input logic [31:0]       bank_stat,
   input logic [ADDR_W-1:0] bank_link,
   input logic              stat_we,
   input logic [31:0]       stat_wdata,
   input logic              saved_we,
   input logic [31:0]       saved_wdata,
   input logic              link_we,
   input logic              pc_we,
   input logic [ADDR_W-1:0] pc_wdata,
   input logic [4:0]        mode_sel,
   input logic              flush,
   input logic              entry_q,
   input logic              ret_q
);

   p_flush_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !flush);

   p_quiet_after_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !(stat_we || pc_we || saved_we || link_we));

   p_flush_writes_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (stat_we && pc_we));

   p_saved_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      saved_we |-> (saved_wdata == $past(stat_in)));

   p_bank_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      saved_we |-> link_we);

   p_entry_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
      entry_q |-> (!stat_wdata[SB_T] && stat_wdata[SB_I] && stat_wdata[4:0] == mode_sel));

   p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_q && mode_sel == MD_IRQ) |-> !$past(stat_in[SB_I]));

   p_fiq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_q && mode_sel == MD_FIQ) |-> !$past(stat_in[SB_F]));

   p_vec_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
      entry_q |-> (pc_wdata[1:0] == 2'b00));

   p_return_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ret_q |-> (stat_wdata == $past(bank_stat) && pc_wdata == $past(bank_link) && !saved_we && !link_we));

   p_return_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ret_q |-> (mode_sel != MD_USR && mode_sel != MD_SYS));

   p_one_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(entry_q && ret_q));

endmodule

bind trap_seq trap_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stat_in     (stat_in),
   .bank_stat   (bank_stat),
   .bank_link   (bank_link),
   .stat_we     (stat_we),
   .stat_wdata  (stat_wdata),
   .saved_we    (saved_we),
   .saved_wdata (saved_wdata),
   .link_we     (link_we),
   .pc_we       (pc_we),
   .pc_wdata    (pc_wdata),
   .mode_sel    (mode_sel),
   .flush       (flush),
   .entry_q     (entry_q),
   .ret_q       (ret_q)
);

// File: tb/trap_seq_tb.sv
module trap_seq_tb;

   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_boot, req_undef, req_svc, req_fetch_abt;
   logic          req_data_abt, req_irq, req_fiq, ret_req;
   logic [31:0]   stat_in, bank_stat;
   logic [AW-1:0] pc_in, bank_link;
   logic          stat_we, saved_we, link_we, pc_we, flush;
   logic [31:0]   stat_wdata, saved_wdata;
   logic [AW-1:0] link_wdata, pc_wdata;
   logic [4:0]    mode_sel;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   trap_seq #(.ADDR_W(AW)) u_dut (
      .clk (clk), .rst_n (rst_n),
      .req_boot (req_boot), .req_undef (req_undef), .req_svc (req_svc),
      .req_fetch_abt (req_fetch_abt), .req_data_abt (req_data_abt),
      .req_irq (req_irq), .req_fiq (req_fiq), .ret_req (ret_req),
      .stat_in (stat_in), .pc_in (pc_in), .bank_stat (bank_stat), .bank_link (bank_link),
      .stat_we (stat_we), .stat_wdata (stat_wdata),
      .saved_we (saved_we), .saved_wdata (saved_wdata),
      .link_we (link_we), .link_wdata (link_wdata),
      .pc_we (pc_we), .pc_wdata (pc_wdata),
      .mode_sel (mode_sel), .flush (flush)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // expected results
   logic          e_stat_we, e_saved_we, e_link_we, e_pc_we, e_flush;
   logic [31:0]   e_stat, e_saved;
   logic [AW-1:0] e_link, e_pc;
   logic [4:0]    e_mode;

   task automatic predict(input logic [6:0] r, input logic ret, input logic [31:0] st,
                          input logic [AW-1:0] pc, input logic [31:0] bs, input logic [AW-1:0] bl);
      int win;
      logic [4:0] md, voff;
      win = -1;
      if (r[0]) win = 0;
      else if (r[1]) win = 1;
      else if (r[2] && !st[6]) win = 2;
      else if (r[3] && !st[7]) win = 3;
      else if (r[4]) win = 4;
      else if (r[5]) win = 5;
      else if (r[6]) win = 6;
      {e_stat_we, e_saved_we, e_link_we, e_pc_we, e_flush} = '0;
      e_stat = '0; e_saved = '0; e_link = '0; e_pc = '0; e_mode = '0;
      md = 5'h13; voff = 5'h00;
      case (win)
         0: begin md = 5'h13; voff = 5'h00; end
         1: begin md = 5'h17; voff = 5'h10; end
         2: begin md = 5'h11; voff = 5'h1C; end
         3: begin md = 5'h12; voff = 5'h18; end
         4: begin md = 5'h17; voff = 5'h0C; end
         5: begin md = 5'h1B; voff = 5'h04; end
         6: begin md = 5'h13; voff = 5'h08; end
         default: ;
      endcase
      if (win >= 0) begin
         e_stat_we = 1'b1; e_pc_we = 1'b1; e_flush = 1'b1;
         e_mode = md;
         e_stat = st;
         e_stat[7] = 1'b1;
         if (win == 0 || win == 2) e_stat[6] = 1'b1;
         e_stat[5] = 1'b0;
         e_stat[4:0] = md;
         e_pc = AW'(voff);
         if (win != 0) begin
            e_saved_we = 1'b1; e_link_we = 1'b1;
            e_saved = st;
            e_link = pc + ((win == 1) ? AW'(8) : AW'(4));
         end
      end else if (ret && st[4:0] != 5'h10 && st[4:0] != 5'h1F) begin
         e_stat_we = 1'b1; e_pc_we = 1'b1; e_flush = 1'b1;
         e_stat = bs; e_pc = bl; e_mode = st[4:0];
      end
   endtask

   task automatic apply(input logic [6:0] r, input logic ret, input logic [31:0] st,
                        input logic [AW-1:0] pc, input logic [31:0] bs, input logic [AW-1:0] bl);
      {req_svc, req_undef, req_fetch_abt, req_irq, req_fiq, req_data_abt, req_boot} = r;
      ret_req = ret; stat_in = st; pc_in = pc; bank_stat = bs; bank_link = bl;
   endtask

   task automatic compare(input string tag_we, input string tag_st, input string tag_pc);
      chk(tag_we, 64'({stat_we, saved_we, link_we, pc_we, flush}),
          64'({e_stat_we, e_saved_we, e_link_we, e_pc_we, e_flush}));
      if (e_flush) chk(tag_we, 64'(mode_sel), 64'(e_mode));
      if (e_stat_we) chk(tag_st, 64'(stat_wdata), 64'(e_stat));
      if (e_pc_we) chk(tag_pc, 64'(pc_wdata), 64'(e_pc));
      if (e_saved_we) chk("R4 saved status", 64'(saved_wdata), 64'(e_saved));
      if (e_link_we) chk("R6 link address", 64'(link_wdata), 64'(e_link));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      apply(7'h7F, 1'b1, 32'h0000_0013, '0, '0, '0);
      repeat (3) @(posedge clk);
      #1;
      // R1: enables quiet during reset even with requests present
      chk("R1 reset quiet", 64'({stat_we, saved_we, link_we, pc_we, flush}), 64'd0);
      @(negedge clk);
      apply(7'h00, 1'b0, 32'h0000_0010, '0, '0, '0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 first cycle", 64'({stat_we, saved_we, link_we, pc_we, flush}), 64'd0);

      // exhaustive sweep over requests and the two disable bits
      for (int idx = 0; idx < 512; idx++) begin
         logic [31:0] st;
         logic [AW-1:0] pc;
         logic [6:0] r;
         logic ret;
         string t_we;
         r   = idx[6:0];
         ret = idx[0] ^ idx[5];
         st  = {idx[3:0] ^ 4'hA, 12'h0, idx[7:0], idx[7], idx[8], 1'b1, 5'h10};
         pc  = 32'h2000_0000 + AW'(idx * 12);
         @(negedge clk);
         apply(r, ret, st, pc, 32'hDEAD_0000, 32'h0000_BEE0);
         predict(r, ret, st, pc, 32'hDEAD_0000, 32'h0000_BEE0);
         if ((r[3] && idx[7]) || (r[2] && idx[8])) t_we = "R2 R3 masked choice";
         else if (ret && e_flush) t_we = "R2 R10 entry beats return";
         else if (ret) t_we = "R9 return in user mode";
         else t_we = "R2 priority";
         @(posedge clk); #1;
         compare(t_we, "R5 entry status", "R7 vector");
         // inputs held across the flush cycle
         @(posedge clk); #1;
         chk("R11 lockout after flush", 64'({stat_we, saved_we, link_we, pc_we, flush}), 64'd0);
      end

      // return sweep over mode codes
      for (int m = 0; m < 7; m++) begin
         logic [4:0] md;
         logic [31:0] st;
         case (m)
            0: md = 5'h10; 1: md = 5'h11; 2: md = 5'h12; 3: md = 5'h13;
            4: md = 5'h17; 5: md = 5'h1B; default: md = 5'h1F;
         endcase
         st = {4'h6, 20'h0, 3'b110, md};
         @(negedge clk);
         apply(7'h00, 1'b1, st, 32'h4000_0040, {4'h9, 20'h12345, 3'b001, 5'h10} ^ 32'(m), 32'h0000_8000 + AW'(m * 4));
         predict(7'h00, 1'b1, st, 32'h4000_0040, {4'h9, 20'h12345, 3'b001, 5'h10} ^ 32'(m), 32'h0000_8000 + AW'(m * 4));
         @(posedge clk); #1;
         compare((md == 5'h10 || md == 5'h1F) ? "R9 return refused" : "R8 return enables",
                 "R8 restored status", "R8 restored pc");
         @(posedge clk); #1;
         chk("R11 lockout after return", 64'({stat_we, pc_we, flush}), 64'd0);
      end

      // IRQ together with return in IRQ mode with IRQ enabled: entry wins
      @(negedge clk);
      apply(7'b0001000, 1'b1, 32'h0000_0012, 32'h0000_0100, 32'h0000_00D0, 32'h0000_0200);
      predict(7'b0001000, 1'b1, 32'h0000_0012, 32'h0000_0100, 32'h0000_00D0, 32'h0000_0200);
      @(posedge clk); #1;
      compare("R10 entry over return", "R10 status from entry", "R10 pc from entry");

      // held request re-taken after the lockout cycle
      @(posedge clk); #1;
      chk("R11 lockout", 64'(flush), 64'd0);
      @(posedge clk); #1;
      chk("R11 retaken after lockout", 64'(flush), 64'd1);
      @(negedge clk);
      apply(7'h00, 1'b0, 32'h0000_0010, '0, '0, '0);
      @(posedge clk); #1;
      @(posedge clk); #1;
      chk("R11 idle", 64'({stat_we, pc_we, flush}), 64'd0);

      finish_run();
   end

endmodule